// File: doc/BRIEF.md
# Serial Voltage-Code Command Receiver

This block listens on a two-wire serial bus, shaped like I2C, that a processor uses to request supply voltages. It oversamples the bus clock and data lines with the system clock, recognises start and stop conditions, and takes in an address byte and a data byte. It acknowledges each of the two bytes by pulling the data line low. A command that is fully received is held back and only applied to the rail code outputs once the stop condition arrives.

The address byte carries a fixed three-bit prefix and two rail-select bits: one for the core rail and one for the auxiliary rail. The data byte carries a 7-bit voltage code and an active-low power-saving permission flag. A rail code of 124 or above means that rail is switched off. A code maps to 1.55 V minus 12.5 mV per step. Reads, clock stretching and transfers of more than one data byte are not supported.

Top module: `svid_rx`

## Requirements
- R1: After synchronous reset both rail codes are 0, both off flags are 0, both update strobes are 0, the power-saving output is 0 and the data pull-down is released.
- R2: A frame is start, 7 address bits, one direction bit, an acknowledge slot, 8 data bits, an acknowledge slot, stop. All bits are sent most-significant first, and each bit is sampled on the rising edge of the bus clock.
- R3: The address is acknowledged only when its bits 6:4 equal 110. Address bits 3 and 2 have no effect. With any other prefix there is no acknowledge and no output changes.
- R4: The direction bit must be 0 (write). If it is 1, the frame gets no acknowledge and no output changes.
- R5: For an accepted address, `sda_pull_o` goes high after the bus clock falls at the end of the 8th bit of the byte. It stays high until the next bus clock falling edge. The same applies after the data byte. At all other times it is low.
- R6: Address bit 1 selects the core rail and bit 0 selects the auxiliary rail. With both set, both rails are loaded. With neither set, the frame is acknowledged but no output changes.
- R7: Received values reach the outputs only after a stop that follows the second acknowledge. A frame without a stop, cut off by a repeated start, changes nothing.
- R8: Each committed command raises the update strobe of every selected rail for exactly one clock cycle.
- R9: Data bit 7 is an active-low permission flag. A committed command that selects at least one rail sets `psave_o` to the inverse of that bit.
- R10: A rail whose committed code is 124 to 127 has its off flag set, and otherwise cleared. The rail that was not addressed keeps its code and its off flag.
- R11: A start condition seen at any point in a frame discards the partial command and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | 1 = pull the data line low (acknowledge) |
| core_code_o | output | 7 | Committed core rail voltage code |
| aux_code_o | output | 7 | Committed auxiliary rail voltage code |
| core_off_o | output | 1 | Core rail switched off (code 124..127) |
| aux_off_o | output | 1 | Auxiliary rail switched off (code 124..127) |
| core_upd_o | output | 1 | One-cycle strobe when the core code is committed |
| aux_upd_o | output | 1 | One-cycle strobe when the auxiliary code is committed |
| psave_o | output | 1 | Power-saving permitted (inverse of data bit 7) |

## Verification
A table of frames drives the main path with every rail-select combination. It uses addresses whose ignored bits are set and data bytes with the flag bit both high and low. It also crosses the off-code boundary at 123 and 124 in both directions, so a wrong rail routing, a lost flag inversion or an off-by-one in the off threshold each show up as a different mismatching output. Frames with a wrong prefix or with the read direction separate the address check from the select decode, because the acknowledge is checked apart from the outputs. Directed frames cut off by a repeated start, inside the address and inside the data byte, and a frame with no stop show whether the commit waits for stop or leaks a partial command.

// File: rtl/svid_pkg.sv
// Shared constants and types for the serial voltage-code receiver.
package svid_pkg;
    localparam int          CODE_W     = 7;
    localparam int          BYTE_W     = 8;
    localparam int          NRAIL      = 2;
    localparam logic [2:0]  ADDR_PFX   = 3'b110;
    localparam int          OFF_MIN    = 124;
    localparam int          CNT_W      = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_A,
        ST_DATA,
        ST_ACK_D,
        ST_DONE
    } rx_state_t;
endpackage

// File: rtl/svid_sync.sv
// Two-or-more flop synchroniser with edge detection for one bus line.
// Assumes the line is idle-high; reset fills the chain with RST_VAL.
module svid_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] q;

    // Shift the asynchronous input through the chain; top bit holds the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= {(STAGES+1){RST_VAL}};
        else        q <= {q[STAGES-1:0], din};
    end

    assign lvl  = q[STAGES-1];
    assign rise =  q[STAGES-1] & ~q[STAGES];
    assign fall = ~q[STAGES-1] &  q[STAGES];
endmodule

// File: rtl/svid_frame.sv
// Frame receiver: start/stop detection, address and data shifting, and
// acknowledge drive. Assumes synchronised line levels and edge pulses.
// Raises commit for one cycle when a stop follows a complete frame.
module svid_frame
    import svid_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              sda_rise,
    input  logic              sda_fall,
    output logic              sda_pull,
    output logic              commit,
    output logic [NRAIL-1:0]  cmd_sel,
    output logic [BYTE_W-1:0] cmd_data
);
    rx_state_t         state;
    logic [BYTE_W-1:0] sr;
    logic [CNT_W-1:0]  cnt;
    logic              start_c;
    logic              stop_c;
    logic              full;

    assign start_c = sda_fall & scl_lvl;
    assign stop_c  = sda_rise & scl_lvl;
    assign full    = (cnt == CNT_W'(BYTE_W));

    // Frame sequencer: shifts bits, drives acknowledge, and commits on stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sr       <= '0;
            cnt      <= '0;
            sda_pull <= 1'b0;
            commit   <= 1'b0;
            cmd_sel  <= '0;
            cmd_data <= '0;
        end else begin
            commit <= 1'b0;
            if (start_c) begin
                state    <= ST_ADDR;
                cnt      <= '0;
                sda_pull <= 1'b0;
            end else if (stop_c) begin
                commit   <= (state == ST_DONE);
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_DATA: begin
                        if (scl_rise && !full) begin
                            sr  <= {sr[BYTE_W-2:0], sda_lvl};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && full) begin
                            if (state == ST_DATA) begin
                                cmd_data <= sr;
                                sda_pull <= 1'b1;
                                state    <= ST_ACK_D;
                            end else if (sr[BYTE_W-1 -: 3] == ADDR_PFX && !sr[0]) begin
                                cmd_sel  <= sr[2:1];
                                sda_pull <= 1'b1;
                                state    <= ST_ACK_A;
                            end else begin
                                state    <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK_A: if (scl_fall) begin
                        sda_pull <= 1'b0;
                        cnt      <= '0;
                        state    <= ST_DATA;
                    end
                    ST_ACK_D: if (scl_fall) begin
                        sda_pull <= 1'b0;
                        state    <= ST_DONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_PULL_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> (state == ST_ACK_A || state == ST_ACK_D)); // R5
    AST_PULL_RELEASE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> $past(scl_fall || start_c || stop_c)); // R5
    AST_COMMIT_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(state == ST_DONE)); // R7
    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit); // R8
endmodule

// File: rtl/svid_rails.sv
// Per-rail code registers, updated only on commit, plus the power-saving flag.
// Rail 0 is the core rail (select bit 1), rail 1 is auxiliary (select bit 0).
module svid_rails
    import svid_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit,
    input  logic [NRAIL-1:0]              cmd_sel,
    input  logic [BYTE_W-1:0]             cmd_data,
    output logic [NRAIL-1:0][CODE_W-1:0]  code_q,
    output logic [NRAIL-1:0]              off_q,
    output logic [NRAIL-1:0]              upd_q,
    output logic                          psave_q
);
    localparam logic [CODE_W-1:0] OFF_CODE = CODE_W'(OFF_MIN);

    genvar i;
    generate
        for (i = 0; i < NRAIL; i++) begin : g_rail
            logic hit;
            assign hit = commit & cmd_sel[NRAIL-1-i];

            // Load this rail's code and off flag when a committed command selects it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    code_q[i] <= '0;
                    off_q[i]  <= 1'b0;
                    upd_q[i]  <= 1'b0;
                end else begin
                    upd_q[i] <= hit;
                    if (hit) begin
                        code_q[i] <= cmd_data[CODE_W-1:0];
                        off_q[i]  <= (cmd_data[CODE_W-1:0] >= OFF_CODE);
                    end
                end
            end

            AST_CODE_MOVES_WITH_UPD: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(code_q[i]) |-> upd_q[i]); // R7
            AST_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
                upd_q[i] |=> !upd_q[i]); // R8
            AST_OFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                off_q[i] == (code_q[i] >= OFF_CODE)); // R10
        end
    endgenerate

    // Capture the inverted permission flag on any command that selects a rail.
    always_ff @(posedge clk) begin
        if (!rst_n)                    psave_q <= 1'b0;
        else if (commit && |cmd_sel)   psave_q <= ~cmd_data[BYTE_W-1];
    end
endmodule

// File: rtl/svid_rx.sv
// Top of the serial voltage-code receiver. Synchronises both bus lines,
// runs the frame receiver and holds the committed rail state.
// Assumes clk runs at least several times faster than the bus clock.
module svid_rx
    import svid_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic [CODE_W-1:0] core_code_o,
    output logic [CODE_W-1:0] aux_code_o,
    output logic              core_off_o,
    output logic              aux_off_o,
    output logic              core_upd_o,
    output logic              aux_upd_o,
    output logic              psave_o
);
    logic [1:0] line_in, line_lvl, line_rise, line_fall;
    logic                          commit;
    logic [NRAIL-1:0]              cmd_sel;
    logic [BYTE_W-1:0]             cmd_data;
    logic [NRAIL-1:0][CODE_W-1:0]  code_q;
    logic [NRAIL-1:0]              off_q, upd_q;

    assign line_in = {sda_i, scl_i};

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_sync
            svid_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (line_in[g]),
                .lvl  (line_lvl[g]),
                .rise (line_rise[g]),
                .fall (line_fall[g])
            );
        end
    endgenerate

    svid_frame u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_lvl (line_lvl[0]),
        .scl_rise(line_rise[0]),
        .scl_fall(line_fall[0]),
        .sda_lvl (line_lvl[1]),
        .sda_rise(line_rise[1]),
        .sda_fall(line_fall[1]),
        .sda_pull(sda_pull_o),
        .commit  (commit),
        .cmd_sel (cmd_sel),
        .cmd_data(cmd_data)
    );

    svid_rails u_rails (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .cmd_sel (cmd_sel),
        .cmd_data(cmd_data),
        .code_q  (code_q),
        .off_q   (off_q),
        .upd_q   (upd_q),
        .psave_q (psave_o)
    );

    assign core_code_o = code_q[0];
    assign aux_code_o  = code_q[1];
    assign core_off_o  = off_q[0];
    assign aux_off_o   = off_q[1];
    assign core_upd_o  = upd_q[0];
    assign aux_upd_o   = upd_q[1];

    AST_NO_DUAL_STROBE_WITHOUT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (core_upd_o && aux_upd_o) |-> $past(cmd_sel == 2'b11)); // R6
endmodule

// File: tb/svid_rx_tb.sv
// Self-checking bench: table of frames with expected results, then directed cases.
module svid_rx_tb;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic [6:0] core_code, aux_code;
    logic core_off, aux_off, core_upd, aux_upd, psave;
    logic sda_wire;

    int n_chk = 0;
    int n_bad = 0;
    int cnt_core = 0;
    int cnt_aux = 0;

    always #4 clk = ~clk;

    assign sda_wire = sda_m & ~sda_pull;

    svid_rx u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_wire),
        .sda_pull_o(sda_pull), .core_code_o(core_code), .aux_code_o(aux_code),
        .core_off_o(core_off), .aux_off_o(aux_off),
        .core_upd_o(core_upd), .aux_upd_o(aux_upd), .psave_o(psave)
    );

    // Count update strobe cycles.
    always @(posedge clk) begin
        if (core_upd) cnt_core <= cnt_core + 1;
        if (aux_upd)  cnt_aux  <= cnt_aux + 1;
    end

    // Fields: addr7 rw data8 ack ucore uaux core7 aux7 coff aoff ps
    localparam int NV = 11;
    localparam logic [35:0] VEC [NV] = '{
        {7'h62,1'b0,8'h90,1'b1,1'b1,1'b0,7'h10,7'h00,1'b0,1'b0,1'b0},
        {7'h61,1'b0,8'h25,1'b1,1'b0,1'b1,7'h10,7'h25,1'b0,1'b0,1'b1},
        {7'h63,1'b0,8'hAA,1'b1,1'b1,1'b1,7'h2A,7'h2A,1'b0,1'b0,1'b0},
        {7'h6E,1'b0,8'h05,1'b1,1'b1,1'b0,7'h05,7'h2A,1'b0,1'b0,1'b1},
        {7'h60,1'b0,8'h7F,1'b1,1'b0,1'b0,7'h05,7'h2A,1'b0,1'b0,1'b1},
        {7'h42,1'b0,8'h11,1'b0,1'b0,1'b0,7'h05,7'h2A,1'b0,1'b0,1'b1},
        {7'h62,1'b1,8'h11,1'b0,1'b0,1'b0,7'h05,7'h2A,1'b0,1'b0,1'b1},
        {7'h62,1'b0,8'hFC,1'b1,1'b1,1'b0,7'h7C,7'h2A,1'b1,1'b0,1'b0},
        {7'h61,1'b0,8'h7F,1'b1,1'b0,1'b1,7'h7C,7'h7F,1'b1,1'b1,1'b1},
        {7'h62,1'b0,8'h7B,1'b1,1'b1,1'b0,7'h7B,7'h7F,1'b0,1'b1,1'b1},
        {7'h61,1'b0,8'h00,1'b1,1'b0,1'b1,7'h7B,7'h00,1'b0,1'b0,1'b1}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(H);
        scl = 1'b1;   tick(H);
        sda_m = 1'b0; tick(H);
        scl = 1'b0;   tick(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H);
        scl = 1'b1;   tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    // One bit, MSB-first order handled by caller; checks pull stays low (R5).
    task automatic bus_bit(input logic b);
        sda_m = b; tick(H);
        scl = 1'b1; tick(H / 2);
        chk("R5 no pull while bit high", sda_pull, 0);
        tick(H / 2);
        scl = 1'b0; tick(2);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) bus_bit(v[i]);
    endtask

    task automatic ack_slot(output logic seen);
        sda_m = 1'b1; tick(H);
        seen = sda_pull;
        scl = 1'b1; tick(H);
        scl = 1'b0; tick(H);
        chk("R5 pull released after ack", sda_pull, 0);
    endtask

    task automatic frame(input logic [6:0] a, input logic rw, input logic [7:0] d,
                         input logic do_stop, output logic ack1, output logic ack2);
        bus_start();
        send_bits({a, rw}, 8);
        ack_slot(ack1);
        send_bits(d, 8);
        ack_slot(ack2);
        if (do_stop) bus_stop();
        tick(H + 4);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1;
        tick(4);
        rst_n = 1'b1;
        tick(2);
    endtask

    initial begin
        logic a1, a2;
        int pc, pa;
        do_reset();
        // R1 reset state
        chk("R1 core code", core_code, 0);
        chk("R1 aux code", aux_code, 0);
        chk("R1 off flags", {core_off, aux_off}, 0);
        chk("R1 strobes", {core_upd, aux_upd}, 0);
        chk("R1 psave", psave, 0);
        chk("R1 pull", sda_pull, 0);

        // Table: R2 R3 R4 R6 R8 R9 R10
        for (int k = 0; k < NV; k++) begin
            logic [35:0] v;
            v = VEC[k];
            pc = cnt_core; pa = cnt_aux;
            frame(v[35:29], v[28], v[27:20], 1'b1, a1, a2);
            chk($sformatf("R3 R4 addr ack vec %0d", k), a1, v[19]);
            chk($sformatf("R5 data ack vec %0d", k), a2, v[19]);
            chk($sformatf("R2 R6 core code vec %0d", k), core_code, v[16:10]);
            chk($sformatf("R2 R6 aux code vec %0d", k), aux_code, v[9:3]);
            chk($sformatf("R10 off flags vec %0d", k), {core_off, aux_off}, v[2:1]);
            chk($sformatf("R9 psave vec %0d", k), psave, v[0]);
            chk($sformatf("R8 core strobe count vec %0d", k), cnt_core - pc, v[18]);
            chk($sformatf("R8 aux strobe count vec %0d", k), cnt_aux - pa, v[17]);
        end

        // R7: frame without stop, then repeated start; only the second applies.
        pc = cnt_core; pa = cnt_aux;
        frame(7'h62, 1'b0, 8'h33, 1'b0, a1, a2);
        chk("R7 no commit before stop", core_code, 7'h7B);
        chk("R7 no strobe before stop", cnt_core - pc, 0);
        frame(7'h61, 1'b0, 8'h44, 1'b1, a1, a2);
        chk("R7 discarded frame left core", core_code, 7'h7B);
        chk("R7 second frame aux", aux_code, 7'h44);
        chk("R7 core strobe count", cnt_core - pc, 0);
        chk("R7 aux strobe count", cnt_aux - pa, 1);

        // R11: start inside the address byte.
        pc = cnt_core;
        bus_start();
        send_bits(8'hC4, 4);
        frame(7'h62, 1'b0, 8'h11, 1'b1, a1, a2);
        chk("R11 restart in address core", core_code, 7'h11);
        chk("R11 restart in address strobes", cnt_core - pc, 1);

        // R11: start inside the data byte.
        pa = cnt_aux;
        bus_start();
        send_bits({7'h61, 1'b0}, 8);
        ack_slot(a1);
        send_bits(8'h7E, 3);
        frame(7'h61, 1'b0, 8'h22, 1'b1, a1, a2);
        chk("R11 restart in data aux", aux_code, 7'h22);
        chk("R11 restart in data strobes", cnt_aux - pa, 1);
        chk("R11 restart in data core kept", core_code, 7'h11);

        // R1 reset after activity.
        do_reset();
        chk("R1 core after reset", core_code, 0);
        chk("R1 aux after reset", aux_code, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule